// File: doc/BRIEF.md
# Multi-Sensor Thermal Threshold Monitor

This block watches a stream of temperature samples from up to sixteen sensors. Each sample carries a 12-bit two's-complement code, a sensor index and a valid strobe. One code step is a tenth of a degree, so software multiplies a code by 100 to get millidegrees. For every sensor the block keeps the newest reading with a valid flag, a lower and an upper threshold, and a critical threshold. Each sample is compared, signed, against the thresholds of its own sensor. A crossing sets a sticky pending bit.

Pending bits drive two level interrupt lines. One line serves the lower and upper crossings and the other serves the critical crossings. The critical group also takes two system events: a watchdog bark and a completed-conversion-cycle notification. Software uses a flat word-addressed register port to read readings and pending bits and to set masks, global enables and thresholds. A pending bit is cleared by writing ones to a clear register and then writing zero to it.

Top module: `thermal_trip_monitor`

Register map (word addresses; a field's position is part of the behaviour):

| Addr | Contents |
|---|---|
| 0x00 | global enables: bit 0 lower, bit 1 upper, bit 2 critical |
| 0x01 | threshold pending (read only): bit n lower of sensor n, bit 16+n upper of sensor n |
| 0x02 | threshold clear, same layout |
| 0x03 | threshold mask, same layout, 1 = suppress |
| 0x04 | critical pending (read only): bit n sensor n, bit 30 cycle event, bit 31 watchdog bark |
| 0x05 | critical clear, same layout |
| 0x06 | critical mask, same layout, 1 = suppress |
| 0x10+n | sensor n limits: lower in 11:0, upper in 23:12 |
| 0x20+n | sensor n report (read only): reading 11:0, lower flag 17, upper flag 18, critical flag 19, valid 21 |
| 0x30+n | sensor n critical limit in 11:0 |

## Requirements
- R1: After reset the register values are as follows. Enables read 0 and both pending registers read 0. The threshold mask reads 0xFFFFFFFF and the critical mask reads 0xC000FFFF for 16 sensors. Every limit word reads 0x007FF800 (upper +2047, lower -2048). Every critical limit reads 0x7FF. Every sensor report reads 0. Both interrupt lines are low.
- R2: A sample with the valid strobe high stores its code in the report bits 11:0 of the indexed sensor and sets report bit 21 at the same clock edge. Both are readable from the next cycle.
- R3: A sample whose signed code is greater than or equal to the sensor's upper limit sets threshold pending bit 16+n and report bit 18.
- R4: A sample whose signed code is less than or equal to the sensor's lower limit sets threshold pending bit n and report bit 17.
- R5: A sample whose signed code is greater than or equal to the sensor's critical limit sets critical pending bit n and report bit 19.
- R6: All comparisons treat codes and limits as signed 12-bit values. The code 0xFFB (-5) crosses neither an upper limit of 200 nor a lower limit of -100.
- R7: Pending bits stay set until cleared. A bit is cleared at each clock edge at which its clear register bit is 1. Once the clear register is back at 0, new crossings latch again. A crossing at the same edge as a clear leaves the bit set.
- R8: A mask bit at 1 keeps its pending bit away from the interrupt line. The pending bit still sets.
- R9: Enable bit 0 gates lower pending bits, bit 1 gates upper pending bits and bit 2 gates critical pending bits onto their lines.
- R10: Each interrupt line is high exactly while at least one enabled and unmasked pending bit of its group is set. It falls once that bit is cleared.
- R11: A watchdog-bark pulse sets critical pending bit 31 and a cycle-done pulse sets bit 30. Critical mask bits 31 and 30 gate these two bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| smp_valid | input | 1 | sample strobe |
| smp_idx | input | SIDX_W (4) | sensor index of the sample |
| smp_code | input | 12 | signed temperature code |
| evt_wdog_bark | input | 1 | watchdog bark event pulse |
| evt_cycle_done | input | 1 | conversion cycle complete pulse |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 6 | register word address |
| reg_wdata | input | 32 | register write data |
| reg_rdata | output | 32 | register read data, combinational from reg_addr |
| irq_thresh | output | 1 | lower/upper interrupt level |
| irq_crit | output | 1 | critical interrupt level |

## Verification
Every stored state reaches the ports within one cycle. If a comparator or latch bit is wrong, the pending register or sensor report shows the wrong bit on the next read after the sample edge. If a clear or mask path is wrong, an interrupt line is at the wrong level in the cycle after the register write. Stickiness is shown by a later non-crossing sample that must not drop the bit. The same-edge race is caught by a read right after a clear and a crossing land together.

// File: rtl/thermal_mon_pkg.sv
package thermal_mon_pkg;
   localparam int TEMP_W = 12;
   typedef logic signed [TEMP_W-1:0] temp_t;

   localparam int REG_AW = 6;
   localparam logic [REG_AW-1:0] A_IRQ_EN  = 6'h00;
   localparam logic [REG_AW-1:0] A_UL_PEND = 6'h01;
   localparam logic [REG_AW-1:0] A_UL_CLR  = 6'h02;
   localparam logic [REG_AW-1:0] A_UL_MASK = 6'h03;
   localparam logic [REG_AW-1:0] A_CR_PEND = 6'h04;
   localparam logic [REG_AW-1:0] A_CR_CLR  = 6'h05;
   localparam logic [REG_AW-1:0] A_CR_MASK = 6'h06;

   localparam logic [1:0] PG_LIMIT  = 2'b01;
   localparam logic [1:0] PG_REPORT = 2'b10;
   localparam logic [1:0] PG_CRIT   = 2'b11;

   localparam int UP_HALF  = 16;
   localparam int UP_LSB   = 12;
   localparam int BIT_CYC  = 30;
   localparam int BIT_BARK = 31;
   localparam int RP_LO    = 17;
   localparam int RP_UP    = 18;
   localparam int RP_CR    = 19;
   localparam int RP_VLD   = 21;

   localparam temp_t TEMP_MAX = 12'sh7FF;
   localparam temp_t TEMP_MIN = 12'sh800;
endpackage

// File: rtl/thermal_event_latch.sv
module thermal_event_latch #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] set_vec,
   input  logic [W-1:0] clr_vec,
   output logic [W-1:0] pend
);
   // a set at the same edge as a clear wins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~clr_vec) | set_vec;
   end
endmodule

// File: rtl/thermal_sensor_slot.sv
module thermal_sensor_slot
   import thermal_mon_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        hit,
   input  temp_t       code,
   input  logic        lim_we,
   input  logic        crit_we,
   input  logic [23:0] wdata,
   output temp_t       lo_lim,
   output temp_t       up_lim,
   output temp_t       cr_lim,
   output temp_t       last_code,
   output logic        have_code,
   output logic        ev_lo,
   output logic        ev_up,
   output logic        ev_cr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_lim    <= TEMP_MIN;
         up_lim    <= TEMP_MAX;
         cr_lim    <= TEMP_MAX;
         last_code <= '0;
         have_code <= 1'b0;
      end else begin
         if (lim_we) begin
            lo_lim <= temp_t'(wdata[TEMP_W-1:0]);
            up_lim <= temp_t'(wdata[UP_LSB+TEMP_W-1:UP_LSB]);
         end
         if (crit_we) cr_lim <= temp_t'(wdata[TEMP_W-1:0]);
         if (hit) begin
            last_code <= code;
            have_code <= 1'b1;
         end
      end
   end

   // compared against limits in force before any same-edge write
   assign ev_up = hit && (code >= up_lim);
   assign ev_lo = hit && (code <= lo_lim);
   assign ev_cr = hit && (code >= cr_lim);
endmodule

// File: rtl/thermal_trip_monitor.sv
module thermal_trip_monitor
   import thermal_mon_pkg::*;
#(
   parameter int NUM_SENS = 16,
   localparam int SIDX_W  = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic [SIDX_W-1:0] smp_idx,
   input  logic [11:0]       smp_code,
   input  logic              evt_wdog_bark,
   input  logic              evt_cycle_done,
   input  logic              reg_we,
   input  logic [5:0]        reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq_thresh,
   output logic              irq_crit
);
   if (NUM_SENS < 1 || NUM_SENS > UP_HALF) begin : g_bad_count
      $error("NUM_SENS must be between 1 and 16");
   end

   function automatic logic [31:0] ul_impl();
      logic [31:0] m = '0;
      for (int k = 0; k < NUM_SENS; k++) begin
         m[k]           = 1'b1;
         m[UP_HALF + k] = 1'b1;
      end
      return m;
   endfunction

   function automatic logic [31:0] cr_impl();
      logic [31:0] m = '0;
      for (int k = 0; k < NUM_SENS; k++) m[k] = 1'b1;
      m[BIT_CYC]  = 1'b1;
      m[BIT_BARK] = 1'b1;
      return m;
   endfunction

   localparam logic [31:0] UL_BITS = ul_impl();
   localparam logic [31:0] CR_BITS = cr_impl();

   logic [2:0]  irq_en;
   logic [31:0] ul_mask, ul_clear, cr_mask, cr_clear;
   logic [31:0] ul_status, cr_status;
   logic [31:0] ul_set, cr_set;

   temp_t lo_lim [NUM_SENS];
   temp_t up_lim [NUM_SENS];
   temp_t cr_lim [NUM_SENS];
   temp_t last_code [NUM_SENS];
   logic [NUM_SENS-1:0] have_code, ev_lo, ev_up, ev_cr;

   wire [1:0] pg     = reg_addr[5:4];
   wire [3:0] pg_idx = reg_addr[3:0];

   for (genvar n = 0; n < NUM_SENS; n++) begin : g_slot
      wire hit_n  = smp_valid && (smp_idx == SIDX_W'(n));
      wire lim_n  = reg_we && (pg == PG_LIMIT) && (pg_idx == 4'(n));
      wire crit_n = reg_we && (pg == PG_CRIT)  && (pg_idx == 4'(n));
      thermal_sensor_slot u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .hit       (hit_n),
         .code      (temp_t'(smp_code)),
         .lim_we    (lim_n),
         .crit_we   (crit_n),
         .wdata     (reg_wdata[23:0]),
         .lo_lim    (lo_lim[n]),
         .up_lim    (up_lim[n]),
         .cr_lim    (cr_lim[n]),
         .last_code (last_code[n]),
         .have_code (have_code[n]),
         .ev_lo     (ev_lo[n]),
         .ev_up     (ev_up[n]),
         .ev_cr     (ev_cr[n])
      );
   end

   always_comb begin
      ul_set = '0;
      cr_set = '0;
      for (int k = 0; k < NUM_SENS; k++) begin
         ul_set[k]           = ev_lo[k];
         ul_set[UP_HALF + k] = ev_up[k];
         cr_set[k]           = ev_cr[k];
      end
      cr_set[BIT_CYC]  = evt_cycle_done;
      cr_set[BIT_BARK] = evt_wdog_bark;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_en   <= '0;
         ul_mask  <= UL_BITS;
         cr_mask  <= CR_BITS;
         ul_clear <= '0;
         cr_clear <= '0;
      end else if (reg_we) begin
         case (reg_addr)
            A_IRQ_EN:  irq_en   <= reg_wdata[2:0];
            A_UL_MASK: ul_mask  <= reg_wdata & UL_BITS;
            A_CR_MASK: cr_mask  <= reg_wdata & CR_BITS;
            A_UL_CLR:  ul_clear <= reg_wdata & UL_BITS;
            A_CR_CLR:  cr_clear <= reg_wdata & CR_BITS;
            default: ;
         endcase
      end
   end

   thermal_event_latch #(.W(32)) u_ul_pend (
      .clk(clk), .rst_n(rst_n), .set_vec(ul_set), .clr_vec(ul_clear), .pend(ul_status)
   );
   thermal_event_latch #(.W(32)) u_cr_pend (
      .clk(clk), .rst_n(rst_n), .set_vec(cr_set), .clr_vec(cr_clear), .pend(cr_status)
   );

   wire [31:0] ul_live = ul_status & ~ul_mask;
   wire [31:0] cr_live = cr_status & ~cr_mask;
   assign irq_thresh = (irq_en[0] && |ul_live[UP_HALF-1:0]) ||
                       (irq_en[1] && |ul_live[31:UP_HALF]);
   assign irq_crit   = irq_en[2] && |cr_live;

   always_comb begin
      reg_rdata = '0;
      case (pg)
         2'b00: begin
            case (reg_addr)
               A_IRQ_EN:  reg_rdata = {29'd0, irq_en};
               A_UL_PEND: reg_rdata = ul_status;
               A_UL_CLR:  reg_rdata = ul_clear;
               A_UL_MASK: reg_rdata = ul_mask;
               A_CR_PEND: reg_rdata = cr_status;
               A_CR_CLR:  reg_rdata = cr_clear;
               A_CR_MASK: reg_rdata = cr_mask;
               default:   reg_rdata = '0;
            endcase
         end
         default: begin
            for (int k = 0; k < NUM_SENS; k++) begin
               if (pg_idx == 4'(k)) begin
                  if (pg == PG_LIMIT)
                     reg_rdata = {8'd0, up_lim[k], lo_lim[k]};
                  else if (pg == PG_CRIT)
                     reg_rdata = {20'd0, cr_lim[k]};
                  else begin
                     reg_rdata[TEMP_W-1:0] = last_code[k];
                     reg_rdata[RP_LO]  = ul_status[k];
                     reg_rdata[RP_UP]  = ul_status[UP_HALF + k];
                     reg_rdata[RP_CR]  = cr_status[k];
                     reg_rdata[RP_VLD] = have_code[k];
                  end
               end
            end
         end
      endcase
   end
endmodule

// File: rtl/thermal_trip_monitor_chk.sv
module thermal_trip_monitor_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        irq_thresh,
   input logic        irq_crit,
   input logic        evt_wdog_bark,
   input logic [2:0]  irq_en,
   input logic [31:0] ul_status,
   input logic [31:0] ul_clear,
   input logic [31:0] cr_status,
   input logic [31:0] cr_clear
);
   AST_LINES_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_thresh && !irq_crit)); // R1

   AST_UL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ul_clear == 32'd0) |=> ((ul_status & $past(ul_status)) == $past(ul_status))); // R7

   AST_CR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_clear == 32'd0) |=> ((cr_status & $past(cr_status)) == $past(cr_status))); // R7

   AST_BARK_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (cr_clear[31] && !evt_wdog_bark) |=> !cr_status[31]); // R11

   AST_CRIT_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en[2] |-> !irq_crit); // R9

   AST_THRESH_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_en[1:0] == 2'b00) |-> !irq_thresh); // R9

   AST_NO_PEND_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ul_status == 32'd0) |-> !irq_thresh); // R10
endmodule

bind thermal_trip_monitor thermal_trip_monitor_chk u_chk (.*);

// File: tb/tb_thermal_trip_monitor.sv
`timescale 1ns/1ps
module tb_thermal_trip_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_valid = 1'b0;
   logic [3:0]  smp_idx = '0;
   logic [11:0] smp_code = '0;
   logic        evt_wdog_bark = 1'b0;
   logic        evt_cycle_done = 1'b0;
   logic        reg_we = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq_thresh, irq_crit;

   int n_run = 0;
   int n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   thermal_trip_monitor dut (.*);

   // idx(4) code(12) up lo cr
   localparam logic [18:0] VEC [10] = '{
      {4'd0, 12'h000, 3'b000},
      {4'd1, 12'h0C8, 3'b100},
      {4'd2, 12'h0C7, 3'b000},
      {4'd3, 12'hF9C, 3'b010},
      {4'd4, 12'hF9D, 3'b000},
      {4'd5, 12'h190, 3'b101},
      {4'd6, 12'h800, 3'b010},
      {4'd7, 12'h7FF, 3'b101},
      {4'd8, 12'hFFB, 3'b000},
      {4'd9, 12'h18F, 3'b100}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic sample(input logic [3:0] i, input logic [11:0] c);
      @(negedge clk);
      smp_valid = 1'b1; smp_idx = i; smp_code = c;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic clear_all();
      wr(6'h02, 32'hFFFF_FFFF); wr(6'h05, 32'hFFFF_FFFF);
      wr(6'h02, 32'h0);         wr(6'h05, 32'h0);
   endtask

   initial begin
      #(200000 * 5);
      n_run++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(6'h00, d); chk("R1 enables", d, 32'h0);
      rd(6'h01, d); chk("R1 thr pending", d, 32'h0);
      rd(6'h03, d); chk("R1 thr mask", d, 32'hFFFF_FFFF);
      rd(6'h06, d); chk("R1 crit mask", d, 32'hC000_FFFF);
      rd(6'h13, d); chk("R1 limits", d, 32'h007F_F800);
      rd(6'h33, d); chk("R1 crit limit", d, 32'h0000_07FF);
      rd(6'h23, d); chk("R1 report", d, 32'h0);
      chk("R1 irq lines", {30'd0, irq_thresh, irq_crit}, 32'h0);

      // limits: upper 200, lower -100, critical 400
      for (int s = 0; s < 16; s++) begin
         wr(6'h10 + 6'(s), 32'h000C_8F9C);
         wr(6'h30 + 6'(s), 32'h0000_0190);
      end

      // R2 R3 R4 R5 R6 table walk
      for (int v = 0; v < 10; v++) begin
         logic [3:0]  ix;
         logic [11:0] c;
         logic up, lo, cr;
         {ix, c, up, lo, cr} = VEC[v];
         clear_all();
         sample(ix, c);
         rd(6'h01, d);
         chk($sformatf("R3/R4/R6 vec%0d thr pending", v), d,
             (32'(up) << (16 + ix)) | (32'(lo) << ix));
         rd(6'h04, d);
         chk($sformatf("R5 vec%0d crit pending", v), d, 32'(cr) << ix);
         rd(6'h20 + 6'(ix), d);
         chk($sformatf("R2 vec%0d report", v), d,
             32'h0020_0000 | (32'(cr) << 19) | (32'(up) << 18) | (32'(lo) << 17) | 32'(c));
      end

      // R7 sticky, clear, re-latch
      clear_all();
      sample(4'd1, 12'h12C);
      sample(4'd1, 12'h000);
      rd(6'h01, d); chk("R7 sticky", d, 32'h0002_0000);
      clear_all();
      rd(6'h01, d); chk("R7 cleared", d, 32'h0);
      sample(4'd1, 12'h0FA);
      rd(6'h01, d); chk("R7 relatch after clear", d, 32'h0002_0000);
      // R7 same-edge crossing beats clear
      wr(6'h02, 32'h0002_0000);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 6'h02; reg_wdata = 32'h0;
      smp_valid = 1'b1; smp_idx = 4'd1; smp_code = 12'h0FA;
      @(negedge clk);
      reg_we = 1'b0; smp_valid = 1'b0;
      rd(6'h01, d); chk("R7 crossing wins", d, 32'h0002_0000);

      // R8 R9 R10 threshold line
      wr(6'h00, 32'h7);
      @(negedge clk); chk("R8 masked line", {31'd0, irq_thresh}, 32'h0);
      wr(6'h03, ~32'h0002_0000);
      @(negedge clk); chk("R10 line high", {31'd0, irq_thresh}, 32'h1);
      wr(6'h00, 32'h5);
      @(negedge clk); chk("R9 upper disabled", {31'd0, irq_thresh}, 32'h0);
      wr(6'h00, 32'h7);
      wr(6'h02, 32'h0002_0000); wr(6'h02, 32'h0);
      @(negedge clk); chk("R10 line falls", {31'd0, irq_thresh}, 32'h0);
      // R9 lower gate
      wr(6'h03, 32'hFFFF_FFF7);
      sample(4'd3, 12'hF00);
      wr(6'h00, 32'h6);
      @(negedge clk); chk("R9 lower disabled", {31'd0, irq_thresh}, 32'h0);
      wr(6'h00, 32'h7);
      @(negedge clk); chk("R9 lower enabled", {31'd0, irq_thresh}, 32'h1);
      clear_all();

      // R11 bark and cycle events
      @(negedge clk); evt_wdog_bark = 1'b1;
      @(negedge clk); evt_wdog_bark = 1'b0;
      rd(6'h04, d); chk("R11 bark pending", d, 32'h8000_0000);
      chk("R8 bark masked", {31'd0, irq_crit}, 32'h0);
      wr(6'h06, 32'h4000_FFFF);
      @(negedge clk); chk("R11 bark unmasked", {31'd0, irq_crit}, 32'h1);
      @(negedge clk); evt_cycle_done = 1'b1;
      @(negedge clk); evt_cycle_done = 1'b0;
      rd(6'h04, d); chk("R11 cycle pending", d, 32'hC000_0000);
      wr(6'h05, 32'h8000_0000); wr(6'h05, 32'h0);
      @(negedge clk); chk("R10 crit falls", {31'd0, irq_crit}, 32'h0);
      rd(6'h04, d); chk("R11 cycle kept", d, 32'h4000_0000);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
   end
endmodule